// File: doc/BRIEF.md
# Dual-Mode Serial Word Deframer

The deframer sits behind a fiber receiver and clock-recovery circuit. It takes the recovered serial clock and data, samples a bit on every rising edge of that clock, finds frames made of a single start bit followed by 24 data bits sent most significant bit first, discards the start bit, and assembles the data into bytes. Each finished byte is handed to a byte-wide FIFO write port one system-clock pulse at a time.

A host-written mode bit picks how a 24-bit word leaves the block. In reply mode (the reset default) every word is widened to 32 bits: a zero byte is written the moment a frame starts, then the three data bytes from most to least significant. In image mode only the two low data bytes are written, narrowing the word to 16 bits. The mode is taken once per frame, at its start bit, so a host write in the middle of a word cannot split that word. If the FIFO reports full when a byte is due, the byte is dropped and a sticky overflow flag is raised for the host to read and clear.

The recovered clock and data are asynchronous to the system clock and are brought in through synchronizer stages. The recovered clock must therefore run well below the system clock (at least four system cycles per bit).

Top module: `serial_deframer`

## Requirements
- R1: After reset the mode is reply (mode bit 0), the overflow flag is 0 and no FIFO write is issued.
- R2: Bits are taken on rising edges of `rx_clk`; the start bit is not stored and the 24 data bits arrive most significant bit first, so data bit 23 is the first bit after the start bit.
- R3: In reply mode (mode bit 0) each frame produces exactly four FIFO writes in this order: 0x00, data[23:16], data[15:8], data[7:0].
- R4: In image mode (mode bit 1) each frame produces exactly two FIFO writes in this order: data[15:8], data[7:0]; no zero byte is written.
- R5: The host register sits at offset 0x1C; a write there sets the mode from `host_wdata[0]`, reads return the mode in bit 0 and the overflow flag in bit 1, and writes to any other offset change nothing (reads elsewhere return 0).
- R6: The mode is captured at each frame's start bit; a mode change written during a frame takes effect from the next frame.
- R7: A byte due while `fifo_full` is high is dropped (no `fifo_wr`) and the overflow flag is set.
- R8: The overflow flag stays set until the host writes offset 0x1C with `host_wdata[1]` = 1; a write with bit 1 = 0 leaves it set.
- R9: The line idles at 0; 0 bits between frames produce no writes; after the 24th data bit the block returns to idle, and a start bit on the very next bit opens the next frame.
- R10: `fifo_wr` is high for a single system-clock cycle per byte, never two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_clk | input | 1 | Recovered serial clock, asynchronous |
| rx_data | input | 1 | Recovered serial data, stable around `rx_clk` rising edges |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 2 | Host write data: bit 0 mode, bit 1 overflow clear |
| host_rdata | output | 2 | Host read data: bit 0 mode, bit 1 overflow flag |
| fifo_full | input | 1 | FIFO cannot accept a byte |
| fifo_wr | output | 1 | One-cycle FIFO write pulse |
| fifo_wdata | output | 8 | Byte written with `fifo_wr` |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong frame state shows as a missing, extra or shifted byte in the FIFO stream of the very frame it hits, visible within a few system cycles after the bit edge that ends the affected byte; a stuck idle state shows as silence on `fifo_wr` for a whole frame. A wrong latched mode shows at the next start bit as a zero byte present or absent and as four writes instead of two. A wrong overflow state shows on the host read of offset 0x1C after the next dropped byte or clear write, and a wrong synchronizer alignment shows as every byte rotated by one bit.

// File: rtl/deframer_pkg.sv
// Shared types for the serial deframer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package deframer_pkg;

    // Output format chosen by the host mode bit.
    typedef enum logic {
        MODE_REPLY = 1'b0,
        MODE_IMAGE = 1'b1
    } rx_mode_e;

endpackage

// File: rtl/rx_edge_sync.sv
// Brings the recovered serial clock and data into the system clock domain
// and emits a one-cycle bit strobe on each rising edge of the serial clock.
// Assumes: the serial clock has at least four system cycles per bit and the
// data is stable for at least two system cycles around its rising edge.
module rx_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk,
    input  logic rx_data,
    output logic bit_stb,
    output logic bit_val
);

    logic [SYNC_STAGES-1:0] clk_sync;
    logic [SYNC_STAGES-1:0] dat_sync;
    logic                   clk_prev;

    // Shift both serial lines through equal-length synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sync <= '0;
            dat_sync <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_sync <= {clk_sync[SYNC_STAGES-2:0], rx_clk};
            dat_sync <= {dat_sync[SYNC_STAGES-2:0], rx_data};
            clk_prev <= clk_sync[SYNC_STAGES-1];
        end
    end

    // Rising edge of the synchronized serial clock marks one received bit.
    always_comb begin
        bit_stb = clk_sync[SYNC_STAGES-1] & ~clk_prev;
        bit_val = dat_sync[SYNC_STAGES-1];
    end

    // R9: a strobe is never followed by another in the next cycle.
    assert_bit_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

endmodule

// File: rtl/frame_shifter.sv
// Finds start bits, shifts data bits in most significant first and latches
// a byte every BYTE_W data bits. Emits a frame-start pulse and byte strobes.
// Assumes: idle line is 0; a 1 seen while idle is the start bit.
module frame_shifter #(
    parameter int WORD_BITS = 24,
    parameter int BYTE_W    = 8,
    localparam int BYTES    = WORD_BITS / BYTE_W,
    localparam int IDX_W    = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int BIT_W    = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              frame_start,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data,
    output logic [IDX_W-1:0]  byte_idx
);

    logic              busy;
    logic [BIT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  idx_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;
    logic              word_done;

    // Last bit of a byte, and last byte of a word.
    always_comb begin
        byte_done = (bit_cnt == BIT_W'(BYTE_W - 1));
        word_done = byte_done && (idx_cnt == IDX_W'(BYTES - 1));
    end

    // Frame state, shift register and byte latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            bit_cnt     <= '0;
            idx_cnt     <= '0;
            shreg       <= '0;
            frame_start <= 1'b0;
            byte_stb    <= 1'b0;
            byte_data   <= '0;
            byte_idx    <= '0;
        end else begin
            frame_start <= 1'b0;
            byte_stb    <= 1'b0;
            if (bit_stb) begin
                if (!busy) begin
                    if (bit_val) begin
                        busy        <= 1'b1;
                        bit_cnt     <= '0;
                        idx_cnt     <= '0;
                        shreg       <= '0;
                        frame_start <= 1'b1;
                    end
                end else begin
                    shreg   <= {shreg[BYTE_W-2:0], bit_val};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (byte_done) begin
                        byte_stb  <= 1'b1;
                        byte_data <= {shreg[BYTE_W-2:0], bit_val};
                        byte_idx  <= idx_cnt;
                        bit_cnt   <= '0;
                        shreg     <= '0;
                        idx_cnt   <= idx_cnt + 1'b1;
                        if (word_done) begin
                            busy <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // R9: the strobe of the word's last byte leaves the block idle.
    assert_word_ends_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_idx == IDX_W'(BYTES - 1)) |-> !busy);

    // R2: a byte strobe is only produced inside a frame.
    assert_byte_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_idx != IDX_W'(BYTES - 1)) |-> busy);

    // R2: frame start and a byte never coincide.
    assert_start_not_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && byte_stb));

endmodule

// File: rtl/byte_writer.sv
// Turns frame-start and byte strobes into FIFO write pulses according to the
// mode latched at frame start; drops bytes while the FIFO is full and keeps
// a sticky overflow flag.
// Assumes: strobes are at least two cycles apart.
module byte_writer #(
    parameter int BYTE_W  = 8,
    parameter int BYTES   = 3,
    parameter int KEEP    = 2,
    localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int CNT_W  = $clog2(BYTES + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  deframer_pkg::rx_mode_e    mode,
    input  logic                      frame_start,
    input  logic                      byte_stb,
    input  logic [BYTE_W-1:0]         byte_data,
    input  logic [IDX_W-1:0]          byte_idx,
    input  logic                      fifo_full,
    input  logic                      ovf_clr,
    output logic                      fifo_wr,
    output logic [BYTE_W-1:0]         fifo_wdata,
    output logic                      ovf_flag
);
    import deframer_pkg::*;

    rx_mode_e          mode_q;
    logic              want_zero;
    logic              want_byte;
    logic              want;
    logic [CNT_W-1:0]  att_cnt;

    // Decide whether a write is due in this cycle.
    always_comb begin
        want_zero = frame_start && (mode == MODE_REPLY);
        want_byte = byte_stb &&
                    ((mode_q == MODE_REPLY) || (byte_idx >= IDX_W'(BYTES - KEEP)));
        want      = want_zero || want_byte;
    end

    // Latch the mode once per frame at its start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_REPLY;
        end else if (frame_start) begin
            mode_q <= mode;
        end
    end

    // Issue the write pulse or drop the byte when the FIFO is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            fifo_wr <= want && !fifo_full;
            if (want) begin
                fifo_wdata <= want_byte ? byte_data : '0;
            end
        end
    end

    // Sticky overflow flag; a new drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (want && fifo_full) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    // Write attempts in the current frame, kept for the budget check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att_cnt <= '0;
        end else if (frame_start) begin
            att_cnt <= want ? CNT_W'(1) : '0;
        end else if (want) begin
            att_cnt <= att_cnt + 1'b1;
        end
    end

    // R3: a reply frame opens with a zero byte when the FIFO has room.
    assert_zero_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode == MODE_REPLY && !fifo_full) |=> (fifo_wr && fifo_wdata == '0));

    // R4: an image frame writes nothing at its start bit.
    assert_image_no_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode == MODE_IMAGE) |=> !fifo_wr);

    // R3/R4: never more writes per frame than the latched mode allows.
    assert_write_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        att_cnt <= ((mode_q == MODE_REPLY) ? CNT_W'(BYTES + 1) : CNT_W'(KEEP)));

    // R10: a write pulse lasts one cycle.
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> !fifo_wr);

    // R8: the flag stays set unless cleared.
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R7: a byte due while full raises the flag in the next cycle.
    assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (want && fifo_full) |=> (ovf_flag && !fifo_wr));

endmodule

// File: rtl/mode_regs.sv
// Host-visible control register: mode bit and overflow clear on write,
// mode and overflow flag on read, at a single offset.
// Assumes: host accesses are single-cycle; reads are combinational.
module mode_regs #(
    parameter int             ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] MODE_OFFSET = 8'h1C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic [1:0]             host_wdata,
    input  logic                   ovf_flag,
    output logic [1:0]             host_rdata,
    output deframer_pkg::rx_mode_e mode,
    output logic                   ovf_clr
);
    import deframer_pkg::*;

    logic hit;

    // Decode the register offset and the overflow clear request.
    always_comb begin
        hit        = (host_addr == MODE_OFFSET);
        ovf_clr    = host_wr && hit && host_wdata[1];
        host_rdata = hit ? {ovf_flag, mode} : 2'b00;
    end

    // Mode bit, updated only by a write at the register offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_REPLY;
        end else if (host_wr && hit) begin
            mode <= rx_mode_e'(host_wdata[0]);
        end
    end

    // R5: the mode holds unless the register offset is written.
    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == MODE_OFFSET) |=> $stable(mode));

endmodule

// File: rtl/serial_deframer.sv
// Top level: synchronizes the recovered serial stream, deframes 24-bit words
// and writes them to a byte FIFO in reply (widened) or image (narrowed) form.
// Assumes: FIFO and clock recovery are outside; rx_clk is much slower than clk.
module serial_deframer #(
    parameter int              WORD_BITS   = 24,
    parameter int              BYTE_W      = 8,
    parameter int              KEEP        = 2,
    parameter int              SYNC_STAGES = 2,
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] MODE_OFFSET = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_clk,
    input  logic              rx_data,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_wdata,
    output logic [1:0]        host_rdata,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              ovf_flag
);
    import deframer_pkg::*;

    localparam int BYTES = WORD_BITS / BYTE_W;
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic              bit_stb;
    logic              bit_val;
    logic              frame_start;
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_data;
    logic [IDX_W-1:0]  byte_idx;
    rx_mode_e          mode;
    logic              ovf_clr;

    rx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_clk  (rx_clk),
        .rx_data (rx_data),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    frame_shifter #(.WORD_BITS(WORD_BITS), .BYTE_W(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .bit_val     (bit_val),
        .frame_start (frame_start),
        .byte_stb    (byte_stb),
        .byte_data   (byte_data),
        .byte_idx    (byte_idx)
    );

    byte_writer #(.BYTE_W(BYTE_W), .BYTES(BYTES), .KEEP(KEEP)) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .frame_start (frame_start),
        .byte_stb    (byte_stb),
        .byte_data   (byte_data),
        .byte_idx    (byte_idx),
        .fifo_full   (fifo_full),
        .ovf_clr     (ovf_clr),
        .fifo_wr     (fifo_wr),
        .fifo_wdata  (fifo_wdata),
        .ovf_flag    (ovf_flag)
    );

    mode_regs #(.ADDR_W(ADDR_W), .MODE_OFFSET(MODE_OFFSET)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ovf_flag   (ovf_flag),
        .host_rdata (host_rdata),
        .mode       (mode),
        .ovf_clr    (ovf_clr)
    );

    // R1: no write can be issued in the first cycle after reset.
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fifo_wr);

endmodule

// File: tb/serial_deframer_tb.sv
`timescale 1ns/1ps
// Directed bench for the serial deframer: one task per scenario.
module serial_deframer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_clk = 1'b0;
    logic       rx_data = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [1:0] host_wdata = 2'b00;
    logic [1:0] host_rdata;
    logic       fifo_full = 1'b0;
    logic       fifo_wr;
    logic [7:0] fifo_wdata;
    logic       ovf_flag;

    int tests = 0;
    int fails = 0;
    logic [7:0] got[$];
    logic prev_wr = 1'b0;
    logic consec_seen = 1'b0;

    always #2.5 clk = ~clk;

    serial_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_data(rx_data),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .ovf_flag(ovf_flag)
    );

    // Collect written bytes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr) got.push_back(fifo_wdata);
            if (fifo_wr && prev_wr) consec_seen = 1'b1;
            prev_wr = fifo_wr;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One serial bit: data set while rx_clk is low, then a full clock period.
    task automatic send_bit(input logic b);
        rx_data = b;
        #20 rx_clk = 1'b1;
        #20 rx_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [23:0] w);
        send_bit(1'b1);
        for (int i = 23; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic settle();
        send_bit(1'b0);
        send_bit(1'b0);
    endtask

    task automatic host_write(input logic [7:0] a, input logic [1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [1:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    // Compare the collected stream against n bytes packed high-first in exp.
    task automatic expect_seq(input string req, input int n, input logic [31:0] exp);
        check(got.size() == n, {req, " byte count"}, got.size(), n);
        if (got.size() == n) begin
            for (int k = 0; k < n; k++) begin
                logic [7:0] e;
                e = exp[8*(n-1-k) +: 8];
                check(got[k] == e, {req, " byte value"}, got[k], e);
            end
        end
        got.delete();
    endtask

    task automatic t_reset();
        logic [1:0] r;
        read_reg(8'h1C, r);
        check(r == 2'b00, "R1 mode/overflow after reset", r, 0);
        check(fifo_wr == 1'b0, "R1 no write after reset", fifo_wr, 0);
        check(got.size() == 0, "R1 no bytes after reset", got.size(), 0);
    endtask

    task automatic t_reply();
        send_frame(24'hA5C33C); settle();
        expect_seq("R3 reply word", 4, 32'h00A5C33C);
        send_frame(24'h800001); settle();
        expect_seq("R2 msb first", 4, 32'h00800001);
    endtask

    task automatic t_image();
        logic [1:0] r;
        host_write(8'h1C, 2'b01);
        read_reg(8'h1C, r);
        check(r[0] == 1'b1, "R5 mode readback", r, 1);
        send_frame(24'h123456); settle();
        expect_seq("R4 image word", 2, 32'h00003456);
    endtask

    task automatic t_bad_offset();
        logic [1:0] r;
        host_write(8'h1C, 2'b00);
        host_write(8'h18, 2'b01);
        read_reg(8'h1C, r);
        check(r[0] == 1'b0, "R5 other offset ignored", r, 0);
        read_reg(8'h18, r);
        check(r == 2'b00, "R5 other offset reads zero", r, 0);
        send_frame(24'h0F0F0F); settle();
        expect_seq("R5 reply kept", 4, 32'h000F0F0F);
    endtask

    task automatic t_idle_and_back_to_back();
        for (int i = 0; i < 10; i++) send_bit(1'b0);
        check(got.size() == 0, "R9 idle zeros give no writes", got.size(), 0);
        send_frame(24'hDEADBE);
        send_frame(24'h010203); settle();
        check(got.size() == 8, "R9 back-to-back count", got.size(), 8);
        if (got.size() == 8) begin
            check(got[3] == 8'hBE && got[4] == 8'h00 && got[7] == 8'h03,
                  "R9 back-to-back bytes", {got[3], got[4], got[7]}, 24'hBE0003);
        end
        got.delete();
    endtask

    task automatic t_mode_mid_frame();
        send_bit(1'b1);
        for (int i = 23; i >= 12; i--) send_bit(i[0]);
        host_write(8'h1C, 2'b01);
        for (int i = 11; i >= 0; i--) send_bit(i[0]);
        settle();
        expect_seq("R6 old mode holds", 4, 32'h00555555 & 32'h00AAAAAA | 32'h00AAAAAA);
        send_frame(24'h777777); settle();
        expect_seq("R6 new mode next frame", 2, 32'h00007777);
        host_write(8'h1C, 2'b00);
    endtask

    task automatic t_overflow();
        logic [1:0] r;
        fifo_full = 1'b1;
        send_frame(24'h445566); settle();
        check(got.size() == 0, "R7 bytes dropped", got.size(), 0);
        read_reg(8'h1C, r);
        check(r[1] == 1'b1, "R7 overflow set", r, 2);
        fifo_full = 1'b0;
        send_frame(24'h112233); settle();
        expect_seq("R8 writes resume", 4, 32'h00112233);
        host_write(8'h1C, 2'b00);
        read_reg(8'h1C, r);
        check(r[1] == 1'b1, "R8 stays set without clear bit", r, 2);
        host_write(8'h1C, 2'b10);
        read_reg(8'h1C, r);
        check(r == 2'b00, "R8 cleared", r, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_reply();
        t_image();
        t_bad_offset();
        t_idle_and_back_to_back();
        t_mode_mid_frame();
        t_overflow();
        check(consec_seen == 1'b0, "R10 single-cycle pulses", consec_seen, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #900000;
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule